// File: doc/BRIEF.md
# Video Memory Access Port

This block is the processor-side window into a video RAM of 16-bit words. The processor talks to it through eight byte-wide register slots. It loads a 16-bit word address one byte at a time and sets a control byte. It then streams data bytes in or out. After every access that it is configured to count, the address advances by a selectable step. Before each RAM access, the stored word address passes through one of four bit-rotation remaps. This lets tile data be written in a different order from the one in which it is stored.

Reads go through a one-word prefetch buffer. Writing either address byte reloads the buffer from the new location. A data read returns one half of the buffer. When that half is the configured trigger byte, the buffer is reloaded from the current location and the address then steps. RAM traffic is allowed only while the display is forced blank or the scan line lies in the vertical blanking region. Outside that window, writes are discarded and reads see zero.

The RAM is an internal array of `2**IDX_W` words. It is indexed by the low `IDX_W` bits of the remapped word address, so higher address bits alias.

Top module: `vram_port`

## Requirements
- R1: Out of reset the word address is 0, the step is 1, the remap is mode 0, the trigger is the high data byte, the prefetch buffer is 0 and `rd_data` is 0.
- R2: Control slot 0 bits 1..0 set the step: 0 gives 1, 1 gives 32, and 2 or 3 give 128. Bit 7 set makes the high data byte the trigger, and clear makes the low byte the trigger. Bits 3..2 pick the remap mode. The other bits are ignored.
- R3: A data access (write or read, slot 3 low, slot 4 high) advances the word address by the step only when its byte is the trigger byte. The non-trigger byte leaves the address unchanged.
- R4: Remaps, where a is the word address. Mode 0 gives a. Mode 1 gives {a[15:8], a[4:0], a[7:5]}. Mode 2 gives {a[15:9], a[5:0], a[8:6]}. Mode 3 gives {a[15:10], a[6:0], a[9:7]}.
- R5: A write to slot 3 stores the byte in the low (even) half of the remapped word. A write to slot 4 stores it in the high (odd) half.
- R6: A write to slot 1 replaces address bits 7..0, and a write to slot 2 replaces bits 15..8. Either write reloads the prefetch buffer from the word at the remapped new address.
- R7: A read of slot 3 returns buffer bits 7..0, and a read of slot 4 returns bits 15..8. If the byte read is the trigger, the buffer is reloaded from the current remapped address and the address then steps.
- R8: RAM access is open when `force_blank` is 1, or when `scan_line` is at least 225 (at least 240 when `tall_frame` is 1).
- R9: While access is closed, data writes leave the RAM unchanged, and buffer reloads load 0. Address stepping still happens.
- R10: The word address is 16 bits and wraps from 0xFFFF to 0x0000 on a step.
- R11: A read of any slot other than 3 and 4 returns the last byte read (open bus). Writes to slots 5 to 7 have no effect.
- R12: `rd_data` takes its new value at the clock edge that samples `reg_rd` and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_sel | input | 3 | Slot: 0 control, 1 address low, 2 address high, 3 data low, 4 data high |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Read byte, registered |
| force_blank | input | 1 | Display forced blank |
| tall_frame | input | 1 | Taller active picture (240 lines) |
| scan_line | input | 9 | Current vertical line |

## Verification
The RAM is first filled word by word with the default settings. Wrong reset defaults for the trigger or the step therefore surface as read-back mismatches. Directed sequences then isolate each step code, each remap mode at an address whose rotated bits differ, the 0xFFFF wrap, and the window edges at lines 224/225 and 239/240. A long random mix of slot writes, reads, window states and control values follows. It exercises orderings such as address writes between half-word accesses, and trigger changes in mid-stream, which the directed cases do not reach.

// File: rtl/vram_port.sv
module vram_port #(
  parameter int IDX_W = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [2:0] reg_sel,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       force_blank,
  input  logic       tall_frame,
  input  logic [8:0] scan_line
);
  localparam int WORDS = 1 << IDX_W;
  localparam logic [2:0] SEL_CTRL = 3'd0, SEL_ALO = 3'd1, SEL_AHI = 3'd2,
                         SEL_DLO = 3'd3, SEL_DHI = 3'd4;

  logic [15:0] word_addr, new_addr, map_cur, map_new, step;
  logic [15:0] pbuf;
  logic [1:0]  step_sel, remap_sel;
  logic        inc_hi, win_open, bump;
  logic [7:0]  mem_lo [WORDS];
  logic [7:0]  mem_hi [WORDS];
  logic [IDX_W-1:0] idx_cur, idx_new;

  function automatic logic [15:0] remap(input logic [15:0] a, input logic [1:0] m);
    case (m)
      2'd1:    remap = {a[15:8],  a[4:0], a[7:5]};
      2'd2:    remap = {a[15:9],  a[5:0], a[8:6]};
      2'd3:    remap = {a[15:10], a[6:0], a[9:7]};
      default: remap = a;
    endcase
  endfunction

  assign win_open = force_blank || (scan_line >= (tall_frame ? 9'd240 : 9'd225));
  assign step     = (step_sel == 2'd0) ? 16'd1 : (step_sel == 2'd1) ? 16'd32 : 16'd128;
  assign new_addr = (reg_sel == SEL_ALO) ? {word_addr[15:8], wr_data} : {wr_data, word_addr[7:0]};
  assign map_cur  = remap(word_addr, remap_sel);
  assign map_new  = remap(new_addr, remap_sel);
  assign idx_cur  = map_cur[IDX_W-1:0];
  assign idx_new  = map_new[IDX_W-1:0];
  assign bump     = (reg_wr || reg_rd) &&
                    ((reg_sel == SEL_DLO && !inc_hi) || (reg_sel == SEL_DHI && inc_hi));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_addr <= '0;
      step_sel  <= 2'd0;
      remap_sel <= 2'd0;
      inc_hi    <= 1'b1;
      pbuf      <= '0;
      rd_data   <= '0;
    end else begin
      if (reg_wr) begin
        case (reg_sel)
          SEL_CTRL: begin
            inc_hi    <= wr_data[7];
            remap_sel <= wr_data[3:2];
            step_sel  <= wr_data[1:0];
          end
          SEL_ALO, SEL_AHI: begin
            word_addr <= new_addr;
            pbuf      <= win_open ? {mem_hi[idx_new], mem_lo[idx_new]} : 16'd0;
          end
          default: ;
        endcase
      end else if (reg_rd) begin
        case (reg_sel)
          SEL_DLO: rd_data <= pbuf[7:0];
          SEL_DHI: rd_data <= pbuf[15:8];
          default: ;
        endcase
        if (bump) pbuf <= win_open ? {mem_hi[idx_cur], mem_lo[idx_cur]} : 16'd0;
      end
      if (bump) word_addr <= word_addr + step;
    end
  end

  always_ff @(posedge clk) begin
    if (reg_wr && win_open) begin
      if (reg_sel == SEL_DLO) mem_lo[idx_cur] <= wr_data;
      if (reg_sel == SEL_DHI) mem_hi[idx_cur] <= wr_data;
    end
  end
endmodule

// File: rtl/vram_port_chk.sv
module vram_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic        reg_rd,
  input logic [2:0]  reg_sel,
  input logic [7:0]  wr_data,
  input logic [7:0]  rd_data,
  input logic [15:0] word_addr,
  input logic [15:0] pbuf,
  input logic        inc_hi,
  input logic [1:0]  step_sel,
  input logic        win_open
);
  AST_ADDR_LO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_sel == 3'd1 |=> word_addr == {$past(word_addr[15:8]), $past(wr_data)}); // R6
  AST_CLOSED_FETCH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && (reg_sel == 3'd1 || reg_sel == 3'd2) && !win_open |=> pbuf == 16'd0); // R9
  AST_NON_TRIGGER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd && !reg_wr && reg_sel == 3'd3 && inc_hi |=> $stable(word_addr)); // R3
  AST_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd && !reg_wr && reg_sel == 3'd4 && inc_hi && step_sel == 2'd0
    |=> word_addr == $past(word_addr) + 16'd1); // R2
  AST_LOW_READ_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd && !reg_wr && reg_sel == 3'd3 |=> rd_data == $past(pbuf[7:0])); // R7
  AST_OPEN_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd && !reg_wr && reg_sel != 3'd3 && reg_sel != 3'd4 |=> $stable(rd_data)); // R11
endmodule

bind vram_port vram_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel),
  .wr_data(wr_data), .rd_data(rd_data), .word_addr(word_addr), .pbuf(pbuf),
  .inc_hi(inc_hi), .step_sel(step_sel), .win_open(win_open)
);

// File: tb/sim_vram_port.sv
`timescale 1ns/1ps
module sim_vram_port;
  localparam int IDX_W = 10;
  localparam int WORDS = 1 << IDX_W;

  logic clk = 0, rst_n = 0, reg_wr = 0, reg_rd = 0, force_blank = 1, tall_frame = 0;
  logic [2:0] reg_sel = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic [8:0] scan_line = 0;
  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  vram_port #(.IDX_W(IDX_W)) u0 (.*);

  logic [7:0]  m_lo [WORDS];
  logic [7:0]  m_hi [WORDS];
  logic [15:0] a_m = 0, bf_m = 0;
  logic [1:0]  st_m = 0, rm_m = 0;
  logic        th_m = 1;
  logic [7:0]  ob_m = 0;

  function automatic logic [15:0] b_remap(input logic [15:0] a, input logic [1:0] m);
    if (m == 1) return {a[15:8], a[4:0], a[7:5]};
    if (m == 2) return {a[15:9], a[5:0], a[8:6]};
    if (m == 3) return {a[15:10], a[6:0], a[9:7]};
    return a;
  endfunction
  function automatic logic b_open();
    return force_blank || scan_line >= (tall_frame ? 9'd240 : 9'd225);
  endfunction
  function automatic logic [15:0] b_step();
    return st_m == 0 ? 16'd1 : st_m == 1 ? 16'd32 : 16'd128;
  endfunction
  function automatic logic [15:0] b_fetch(input logic [15:0] a);
    logic [15:0] r = b_remap(a, rm_m);
    if (!b_open()) return 16'd0;
    return {m_hi[r[IDX_W-1:0]], m_lo[r[IDX_W-1:0]]};
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic do_wr(input logic [2:0] s, input logic [7:0] d);
    logic [15:0] r = b_remap(a_m, rm_m);
    @(negedge clk);
    reg_wr = 1; reg_sel = s; wr_data = d;
    @(negedge clk);
    reg_wr = 0;
    case (s)
      0: begin th_m = d[7]; rm_m = d[3:2]; st_m = d[1:0]; end
      1: begin a_m[7:0] = d; bf_m = b_fetch(a_m); end
      2: begin a_m[15:8] = d; bf_m = b_fetch(a_m); end
      3: begin if (b_open()) m_lo[r[IDX_W-1:0]] = d; if (!th_m) a_m += b_step(); end
      4: begin if (b_open()) m_hi[r[IDX_W-1:0]] = d; if (th_m) a_m += b_step(); end
      default: ;
    endcase
  endtask

  task automatic do_rd(input logic [2:0] s, input string tag);
    logic [7:0] e = ob_m;
    @(negedge clk);
    reg_rd = 1; reg_sel = s;
    @(negedge clk);
    reg_rd = 0;
    if (s == 3) begin
      e = bf_m[7:0];
      if (!th_m) begin bf_m = b_fetch(a_m); a_m += b_step(); end
    end else if (s == 4) begin
      e = bf_m[15:8];
      if (th_m) begin bf_m = b_fetch(a_m); a_m += b_step(); end
    end
    ob_m = e;
    chk(tag, rd_data, e);
  endtask

  task automatic set_addr(input logic [15:0] a);
    do_wr(2, a[15:8]);
    do_wr(1, a[7:0]);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset buffer and open-bus byte are zero
    do_rd(0, "R1");
    do_rd(3, "R1");
    // fill with defaults (trigger high, step 1), so wrong defaults show on read-back (R1, R5)
    set_addr(0);
    for (int i = 0; i < WORDS; i++) begin
      do_wr(3, 8'(i) ^ 8'h5A);
      do_wr(4, 8'(i >> 2) ^ 8'hC3);
    end
    set_addr(16'h0005);
    do_rd(3, "R5"); do_rd(4, "R5"); do_rd(4, "R7");
    // R12: value held until next read
    repeat (3) @(negedge clk);
    chk("R12", rd_data, ob_m);
    // R2/R3: step 32 with low trigger
    do_wr(0, 8'h01);
    set_addr(16'h0010);
    do_rd(3, "R2"); do_rd(3, "R2"); do_rd(4, "R3"); do_rd(3, "R3");
    do_wr(0, 8'h82); set_addr(16'h0003); do_rd(4, "R2"); do_rd(4, "R2");
    do_wr(0, 8'h83); set_addr(16'h0100); do_rd(3, "R3"); do_rd(4, "R2");
    // R4: each remap mode, write then read back unmapped
    for (int m = 1; m < 4; m++) begin
      do_wr(0, 8'h80 | 8'(m << 2));
      set_addr(16'h02A7);
      do_wr(3, 8'hE0 + 8'(m));
      do_wr(4, 8'hF0 + 8'(m));
      do_wr(0, 8'h80);
      set_addr(b_remap(16'h02A7, 2'(m)));
      do_rd(3, "R4"); do_rd(4, "R4");
    end
    // R10: wrap
    do_wr(0, 8'h00);
    set_addr(16'hFFFF);
    do_wr(3, 8'h11); do_wr(3, 8'h22);
    set_addr(16'h0000); do_rd(3, "R10");
    // R8/R9: window edges
    force_blank = 0; tall_frame = 0; scan_line = 224;
    do_wr(3, 8'h99); set_addr(16'h0040); do_rd(3, "R9");
    scan_line = 225; set_addr(16'h0040); do_rd(3, "R8");
    tall_frame = 1; scan_line = 239; set_addr(16'h0041); do_rd(3, "R9");
    scan_line = 240; set_addr(16'h0041); do_rd(3, "R8");
    // R11: unused slots
    do_wr(5, 8'hFF); do_wr(7, 8'h00); do_rd(6, "R11"); do_rd(1, "R11");
    // random mix
    for (int n = 0; n < 4000; n++) begin
      logic [2:0] s = 3'($urandom_range(0, 7));
      force_blank = ($urandom_range(0, 3) == 0);
      tall_frame  = 1'($urandom);
      scan_line   = 9'($urandom_range(200, 261));
      if ($urandom_range(0, 1) == 0) begin
        logic [7:0] d = 8'($urandom);
        if (s == 2 || s == 1) d = (s == 2) ? 8'($urandom_range(0, 7)) : d;
        do_wr(s, d);
      end else do_rd(s, (s == 3 || s == 4) ? "R7" : "R11");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule